// File: doc/BRIEF.md
# Sequenced Floating-Point Accumulating Adder

This block adds two unsigned floating-point values over a series of clock cycles. A small step sequencer moves the operands through dedicated working registers, one step at a time: four loads, an exponent compare, alignment of the smaller operand, a mantissa add, and normalisation with a range check. The sum replaces operand A in an output register. The operation is therefore destructive, A becoming A + B.

Each operand is a 24-bit word. Bits 23:16 hold an 8-bit biased exponent and bits 15:0 hold a 16-bit mantissa whose leading one sits at bit 15. There is no sign, no rounding and no special value.

The control pins are plain, with no stream handshake. `start` works like a valid that the block only accepts while `busy` is low, so `busy` is the inverse of ready and there is no back-pressure beyond it. An operand word must be stable during the cycle in which `start` is accepted.

Top module: `fpadd_seq`

## Requirements
- R1: Operand and result words use bits 23:16 as the exponent and bits 15:0 as the mantissa, with the value's leading one expected at bit 15.
- R2: `start` is accepted only in a cycle where `busy` is low. A `start` raised while an operation is running has no effect on that result and does not queue a second operation.
- R3: `busy` is high from the cycle after acceptance until the result is written. `done` is high for exactly one cycle, in the cycle in which the new result first appears on `a_out`, and `busy` is low in that cycle.
- R4: The operand with the smaller exponent has its mantissa shifted right by the exponent difference, with the shifted-out bits discarded. A difference of 16 or more makes that mantissa zero. The working result exponent starts at the larger exponent.
- R5: If the mantissa add carries out, the sum is shifted right one bit and the exponent is increased by one.
- R6: Without a carry, the sum is shifted left one bit per cycle and the exponent is decreased by one each time, until bit 15 is set.
- R7: If normalisation would raise the exponent above 255, `ovf` is set and the result is written as exponent 255 with mantissa 0xFFFF.
- R8: If normalisation would lower the exponent below 0, `unf` is set and the result is written as all zeros.
- R9: A zero mantissa sum gives an all-zero result with neither flag set.
- R10: `a_out` resets to zero and changes only in a `done` cycle. `ovf` and `unf` are cleared when a new operation is accepted and are never set together.
- R11: `done` rises 9 clock edges after the accepting edge when normalisation takes a single step, and each left shift adds one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new add; taken only while idle |
| a_in | input | 24 | Operand A word, sampled on acceptance |
| b_in | input | 24 | Operand B word, sampled on acceptance |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is written |
| a_out | output | 24 | Result register, the new value of A |
| ovf | output | 1 | Exponent overflow on the last operation |
| unf | output | 1 | Exponent underflow on the last operation |

## Verification
The sweep covers exponent differences of 0, 15, 16 and 17. A shifter that does not saturate would, at a difference of 16 or more, let bits of the small mantissa leak into the sum. Carry sums taken at exponent 254 and 255 separate a correct increment from an overflow that is missed or wraps. Unnormalised inputs at low exponents check that the left-shift loop stops at exponent zero and raises the underflow flag, rather than wrapping to 255. Zero mantissas check the no-flag zero result, and the latency is checked on every operation. A `start` raised during a run checks that the first result is kept and that no second operation is queued.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LD_EA, S_LD_MA, S_LD_EB, S_LD_MB,
    S_CMP, S_ALIGN, S_ADD, S_NORM, S_WB
  } step_t;
endpackage

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter int MAN_W = 16,
  parameter int SH_W  = 8
) (
  input  logic [MAN_W-1:0] m_i,
  input  logic [SH_W-1:0]  shamt,
  output logic [MAN_W-1:0] m_o
);
  localparam logic [SH_W-1:0] LIM = SH_W'(MAN_W);

  // Differences at or beyond the mantissa width flush it to zero (R4)
  always_comb begin
    if (shamt >= LIM) m_o = '0;
    else              m_o = m_i >> shamt;
  end
endmodule

// File: rtl/fpadd_norm_step.sv
module fpadd_norm_step #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic [MAN_W:0]   mo_i,
  input  logic [EXP_W-1:0] eo_i,
  output logic [MAN_W:0]   mo_o,
  output logic [EXP_W-1:0] eo_o,
  output logic             last,
  output logic             ovf,
  output logic             unf
);
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  always_comb begin
    mo_o = mo_i;
    eo_o = eo_i;
    last = 1'b1;
    ovf  = 1'b0;
    unf  = 1'b0;
    if (mo_i == '0) begin
      last = 1'b1;                       // zero sum, no flag (R9)
    end else if (mo_i[MAN_W]) begin      // carry out (R5)
      if (eo_i == EXP_MAX) ovf = 1'b1;   // R7
      else begin
        mo_o = mo_i >> 1;
        eo_o = eo_i + 1'b1;
      end
    end else if (!mo_i[MAN_W-1]) begin   // left shift loop (R6)
      if (eo_i == '0) unf = 1'b1;        // R8
      else begin
        mo_o = mo_i << 1;
        eo_o = eo_i - 1'b1;
        last = 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpadd_seq.sv
module fpadd_seq #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [EXP_W+MAN_W-1:0] a_in,
  input  logic [EXP_W+MAN_W-1:0] b_in,
  output logic                   busy,
  output logic                   done,
  output logic [EXP_W+MAN_W-1:0] a_out,
  output logic                   ovf,
  output logic                   unf
);
  import fpadd_pkg::*;

  localparam int W = EXP_W + MAN_W;
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  step_t            st;
  logic [W-1:0]     opa, opb, a_reg;
  logic [EXP_W-1:0] e1, e2, eo, shamt;
  logic [MAN_W-1:0] m1, m2, al_in, al_out;
  logic [MAN_W:0]   mo, mo_nx;
  logic [EXP_W-1:0] eo_nx;
  logic             shift_b, done_r, ovf_r, unf_r;
  logic             n_last, n_ovf, n_unf;

  assign al_in = shift_b ? m2 : m1;

  fpadd_align #(.MAN_W(MAN_W), .SH_W(EXP_W)) u_align (
    .m_i(al_in), .shamt(shamt), .m_o(al_out)
  );

  fpadd_norm_step #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .mo_i(mo), .eo_i(eo), .mo_o(mo_nx), .eo_o(eo_nx),
    .last(n_last), .ovf(n_ovf), .unf(n_unf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      opa <= '0; opb <= '0; a_reg <= '0;
      e1 <= '0; e2 <= '0; eo <= '0; shamt <= '0;
      m1 <= '0; m2 <= '0; mo <= '0;
      shift_b <= 1'b0; done_r <= 1'b0; ovf_r <= 1'b0; unf_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin      // R2: taken only here
          opa <= a_in; opb <= b_in;
          ovf_r <= 1'b0; unf_r <= 1'b0;
          st <= S_LD_EA;
        end
        S_LD_EA: begin e1 <= opa[W-1:MAN_W]; st <= S_LD_MA; end
        S_LD_MA: begin m1 <= opa[MAN_W-1:0]; st <= S_LD_EB; end
        S_LD_EB: begin e2 <= opb[W-1:MAN_W]; st <= S_LD_MB; end
        S_LD_MB: begin m2 <= opb[MAN_W-1:0]; st <= S_CMP; end
        S_CMP: begin
          if (e1 >= e2) begin
            shamt <= e1 - e2; eo <= e1; shift_b <= 1'b1;
          end else begin
            shamt <= e2 - e1; eo <= e2; shift_b <= 1'b0;
          end
          st <= S_ALIGN;
        end
        S_ALIGN: begin
          if (shift_b) m2 <= al_out;
          else         m1 <= al_out;
          st <= S_ADD;
        end
        S_ADD: begin
          mo <= {1'b0, m1} + {1'b0, m2};
          st <= S_NORM;
        end
        S_NORM: begin
          mo <= mo_nx; eo <= eo_nx;
          ovf_r <= n_ovf; unf_r <= n_unf;
          if (n_last) st <= S_WB;
        end
        S_WB: begin
          if (ovf_r)          a_reg <= {EXP_MAX, {MAN_W{1'b1}}};
          else if (unf_r)     a_reg <= '0;
          else if (mo == '0)  a_reg <= '0;
          else                a_reg <= {eo, mo[MAN_W-1:0]};
          done_r <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy  = (st != S_IDLE);
  assign done  = done_r;
  assign a_out = a_reg;
  assign ovf   = ovf_r;
  assign unf   = unf_r;

  // R3: done is a single-cycle pulse and coincides with idle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R4: working exponent after compare is the larger one
  p_eo_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADD) |-> (eo >= e1 && eo >= e2));
  // R6: a result written without flags is normalised
  p_wb_norm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB && !ovf_r && !unf_r && mo != '0) |-> (mo[MAN_W:MAN_W-1] == 2'b01));
  // R10: result register changes only with done; flags exclusive
  p_a_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(a_out) |-> done);
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));
endmodule

// File: tb/tb_fpadd_seq.sv
`timescale 1ns/1ps
module tb_fpadd_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, busy, done, ovf, unf;
  logic [23:0] a_in, b_in, a_out;
  int n_run = 0, n_fail = 0;

  fpadd_seq dut (.clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in),
    .b_in(b_in), .busy(busy), .done(done), .a_out(a_out), .ovf(ovf), .unf(unf));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Arithmetic reference built from R1, R4-R9, R11
  task automatic model(input logic [23:0] a, input logic [23:0] b,
                       output logic [23:0] r, output bit ov, output bit un,
                       output int ncyc);
    int ea, eb, ma, mb, e, d, s;
    ea = int'(a[23:16]); eb = int'(b[23:16]);
    ma = int'(a[15:0]);  mb = int'(b[15:0]);
    ov = 0; un = 0; ncyc = 1;
    if (ea >= eb) begin
      d = ea - eb; mb = (d >= 16) ? 0 : (mb >> d); e = ea;
    end else begin
      d = eb - ea; ma = (d >= 16) ? 0 : (ma >> d); e = eb;
    end
    s = ma + mb;
    r = '0;
    if (s == 0) r = '0;
    else if (s >= 65536) begin
      if (e == 255) begin ov = 1; r = 24'hFFFFFF; end
      else r = {8'(e + 1), 16'(s >> 1)};
    end else begin
      while (s < 32768 && !un) begin
        if (e == 0) un = 1;
        else begin s = s << 1; e = e - 1; ncyc++; end
      end
      r = un ? 24'h0 : {8'(e), 16'(s)};
    end
  endtask

  task automatic run_op(input logic [23:0] a, input logic [23:0] b,
                        input string req, input bit poke);
    logic [23:0] exp_r, prev;
    bit ov, un, hold_ok, busy_ok;
    int ncyc, lat;
    model(a, b, exp_r, ov, un, ncyc);
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    prev = a_out; hold_ok = 1; busy_ok = 1; lat = 0;
    while (!done && lat < 200) begin
      if (a_out != prev) hold_ok = 0;
      if (!busy) busy_ok = 0;
      if (poke && lat == 3) begin   // R2: start while busy
        start = 1'b1; a_in = ~a; b_in = ~b;
      end
      @(posedge clk); lat++;
      @(negedge clk);
      start = 1'b0;
    end
    chk(done, "R3", "done seen", 32'(lat), 32'(8 + ncyc));
    chk(a_out == exp_r, req, "result", 32'(a_out), 32'(exp_r));
    chk(ovf == ov && unf == un, "R7/R8 flags", "ovf,unf", {ovf, unf}, {ov, un});
    chk(lat == 8 + ncyc, "R11", "latency", 32'(lat), 32'(8 + ncyc));
    chk(hold_ok && busy_ok && !busy, "R10", "hold/busy", {hold_ok, busy_ok, busy}, 3'b110);
    @(negedge clk);
    chk(!done && !busy && a_out == exp_r, "R3", "done width / no queued op",
        {done, busy}, 2'b00);
  endtask

  initial begin
    #1500000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  exps [9] = '{8'd0, 8'd1, 8'd2, 8'd15, 8'd16, 8'd17, 8'd127, 8'd254, 8'd255};
    logic [15:0] mans [6] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h4000, 16'h1234};
    rst_n = 1'b0; start = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(a_out == 0 && !busy && !done && !ovf && !unf, "R10", "reset state",
        {a_out, busy, done, ovf, unf}, 0);

    // Directed corners
    run_op({8'd100, 16'h8000}, {8'd100, 16'h8000}, "R5", 0); // carry
    run_op({8'd254, 16'hC000}, {8'd254, 16'hC000}, "R5", 0); // carry to 255
    run_op({8'd255, 16'hC000}, {8'd255, 16'hC000}, "R7", 0); // overflow
    run_op({8'd3, 16'h0001}, {8'd3, 16'h0000}, "R8", 0);     // underflow
    run_op({8'd20, 16'h0000}, {8'd9, 16'h0000}, "R9", 0);    // zero sum
    run_op({8'd40, 16'h0101}, {8'd40, 16'h0100}, "R6", 0);   // long left shift
    run_op({8'd80, 16'h9000}, {8'd10, 16'h8000}, "R2", 1);   // start while busy
    run_op({8'd10, 16'h8000}, {8'd80, 16'h9000}, "R1", 0);   // exponent from B
    for (int d = 0; d <= 20; d++)
      run_op({8'd120, 16'hFFFF}, {8'(120 - d), 16'hFFFF}, "R4", 0);

    // Sweep over exponent and mantissa corners
    foreach (exps[i]) foreach (exps[j]) foreach (mans[k]) foreach (mans[l])
      if ((k + l) % 3 == 0)
        run_op({exps[i], mans[k]}, {exps[j], mans[l]}, "R4", 0);

    // Pseudo-random operands
    for (int n = 0; n < 600; n++)
      run_op(24'($urandom), 24'($urandom), "R6", 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule